// File: doc/BRIEF.md
# Serial Memory Command Sequencer

This block sits behind a byte receiver and in front of a small non-volatile style storage array. It takes received bytes one at a time, decodes each opcode, gathers the address and data bytes that opcode needs, and then runs the command: a single-word read, a streamed read to the top of the array, a one-word program or erase, or a whole-array fill. Every program operation starts a self-timed cycle whose length is a parameter counted in clocks. While that cycle runs, the block reports busy. If busy indication has been turned on, it can also show busy on a data-line pair.

The array can be used as 512 words of 8 bits or as 256 words of 16 bits. The organisation opcode selects between the two, and the same 512 bytes of storage are shared by both views. Commands that touch the array first ask an external access controller whether the operation is permitted. Opcodes that belong to that controller (pointer and access-code handling, program disable) are handed over to it byte by byte until it reports that it is done. An unknown opcode or a byte with a parity error stops the block until chip select is taken low. The error cause stays readable in the status byte until it has been read once.

Top module: `serial_mem_sequencer`

## Requirements
- R1: After rst_n, busy, errOut, doOe and txValid are 0, the organisation is 8-bit, busy indication is off, and a status read returns 8'hA0.
- R2: READ (8'hC9) returns one byte in 8-bit mode, addressed by two bytes with the high byte first (its bit 0 is address bit 8). In 16-bit mode it takes one address byte and returns the high byte and then the low byte. The first byte is on txByte in the cycle after the last address byte, and one byte is consumed per cycle while txReady is 1.
- R3: WRITE (8'hC1) stores its data after the address: one byte in 8-bit mode, high byte then low byte in 16-bit mode. ERASE (8'hC0) sets the addressed word to all ones.
- R4: A granted program command makes busy 1 for exactly PROG_CYCLES cycles, starting in the cycle after its last byte. A program command that completes while busy is 1 is dropped.
- R5: Clear-all (8'h89) sets the whole array to 8'hFF only when it is received as two consecutive opcodes. A single 8'h89 followed by any other opcode has no effect on the array.
- R6: Clear-all followed by 8'hC3 and its data (one byte in 8-bit mode, two bytes in 16-bit mode) writes that data to every word.
- R7: A status read (8'hC8) returns {1,0,1,parityErr,instrErr,busy,0,0}, with busy taken in the cycle the opcode is received. The read clears both error bits.
- R8: An opcode outside the decoded set sets instrErr and drives errOut to 1. All input is then ignored until cs is low for a cycle. Taking cs low clears errOut but keeps the organisation and the busy-indication setting.
- R9: A byte received with rxParErr set records a parity error and enters the same stopped state as R8.
- R10: After 8'h84, a program command drives doOe to 1, with doLevel 0 while busy and 1 afterwards. doOe returns to 0 once an opcode is received while not busy. After 8'h85, doOe stays 0.
- R11: Read-sequential (8'hCB) streams bytes from the start address up to byte 511. Taking cs low ends the stream at once.
- R12: When permOk is 0 for a pending command, the command is dropped: no data is changed, busy is not raised and nothing is sent.
- R13: Opcodes 8'hC4, 8'hCA, 8'hC5, 8'h88 and 8'h82 are forwarded on fwdValid/fwdByte, together with every following byte, until fwdDone is 1. Decoding then resumes.
- R14: 8'h87 selects 16-bit words and 8'h86 selects 8-bit words. In 16-bit mode, word w occupies bytes 2w (high) and 2w+1 (low) of the shared storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; low aborts the current command and clears the stopped state |
| rxValid | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| rxParErr | input | 1 | The received byte failed its parity check |
| txReady | input | 1 | The output side takes the presented byte |
| txValid | output | 1 | A read byte is presented |
| txByte | output | 8 | Read byte |
| doOe | output | 1 | The busy level is driven on the data line |
| doLevel | output | 1 | Data-line level: 0 busy, 1 ready |
| busy | output | 1 | Program cycle in progress |
| errOut | output | 1 | Stopped on an instruction or parity error |
| permWordAddr | output | 9 | Word address of the pending command |
| permProg | output | 1 | The pending command programs the array |
| permAll | output | 1 | The pending command covers the whole array |
| permOk | input | 1 | Access controller grants the pending command |
| fwdValid | output | 1 | A byte is forwarded to the access controller |
| fwdByte | output | 8 | Forwarded byte |
| fwdDone | input | 1 | The access controller has finished its command |

## Verification
On every cycle, the assertions check four things: busy only rises after a program strobe, the stream pointer never passes its end, the stopped state holds until chip select drops and lifts when it does, and no byte is forwarded while the block is stopped. Only the scenarios can show the values that come out: the byte order of each organisation, erase and fill contents, the double clear-all rule, the status encoding, and data-line busy indication. The same holds for a dropped command leaving the array unchanged. The bench's reference model predicts every output byte and the busy level on each clock.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int ByteAddrW = 9;
  localparam int NumBytes  = 1 << ByteAddrW;

  localparam logic [7:0] OP_READ   = 8'hC9;
  localparam logic [7:0] OP_WRITE  = 8'hC1;
  localparam logic [7:0] OP_ERASE  = 8'hC0;
  localparam logic [7:0] OP_RSEQ   = 8'hCB;
  localparam logic [7:0] OP_STAT   = 8'hC8;
  localparam logic [7:0] OP_FILL   = 8'hC3;
  localparam logic [7:0] OP_CLRALL = 8'h89;
  localparam logic [7:0] OP_WPTR   = 8'hC4;
  localparam logic [7:0] OP_RPTR   = 8'hCA;
  localparam logic [7:0] OP_ENACC  = 8'hC5;
  localparam logic [7:0] OP_DISACC = 8'h88;
  localparam logic [7:0] OP_PEDIS  = 8'h82;
  localparam logic [7:0] OP_BSYON  = 8'h84;
  localparam logic [7:0] OP_BSYOFF = 8'h85;
  localparam logic [7:0] OP_NOP    = 8'h80;
  localparam logic [7:0] OP_ORG8   = 8'h86;
  localparam logic [7:0] OP_ORG16  = 8'h87;

  typedef enum logic [2:0] {S_IDLE, S_ADRH, S_ADRL, S_DATH, S_DATL, S_FWD, S_ERR} seqState_e;

  typedef struct packed {
    logic                 progOne;
    logic                 progAll;
    logic                 readOne;
    logic                 readSeq;
    logic                 readStat;
    logic                 opcodeSeen;
    logic                 abort;
    logic [ByteAddrW-1:0] wordAddr;
    logic [15:0]          wordData;
  } dpStrobe_t;
endpackage

// File: rtl/seqcmd_ctrl.sv
module seqcmd_ctrl
  import seqcmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 rxValid,
  input  logic [7:0]           rxByte,
  input  logic                 rxParErr,
  input  logic                 busy,
  input  logic                 permOk,
  input  logic                 fwdDone,
  output dpStrobe_t            st,
  output logic [ByteAddrW-1:0] permWordAddr,
  output logic                 permProg,
  output logic                 permAll,
  output logic                 fwdValid,
  output logic [7:0]           fwdByte,
  output logic                 errOut,
  output logic                 parErr,
  output logic                 instrErr,
  output logic                 busyEn,
  output logic                 org16
);
  seqState_e state, nState;
  logic [7:0] op, nOp, dataHi, nDataHi;
  logic addrHi, nAddrHi, armed, nArmed, nBusyEn, nOrg;
  logic [ByteAddrW-1:0] wordReg, nWord, candAddr;
  logic [15:0] candData;
  logic candProg, candAll, candRd, candSeq, stat, badOp, parHit, fwdOpen;

  always_comb begin
    nState = state; nOp = op; nAddrHi = addrHi; nDataHi = dataHi; nWord = wordReg;
    nArmed = armed; nBusyEn = busyEn; nOrg = org16;
    candProg = 1'b0; candAll = 1'b0; candRd = 1'b0; candSeq = 1'b0;
    stat = 1'b0; badOp = 1'b0; parHit = 1'b0; fwdOpen = 1'b0;
    candData = 16'hFFFF;
    candAddr = org16 ? {1'b0, rxByte} : {addrHi, rxByte};
    if (!cs) begin
      nState = S_IDLE;
      nArmed = 1'b0;
    end else if (rxValid && state != S_ERR) begin
      if (rxParErr) begin
        parHit = 1'b1;
        nState = S_ERR;
      end else begin
        case (state)
          S_IDLE: begin
            nOp = rxByte;
            nArmed = 1'b0;
            case (rxByte)
              OP_READ, OP_RSEQ, OP_ERASE, OP_WRITE: nState = org16 ? S_ADRL : S_ADRH;
              OP_CLRALL: if (armed) candAll = 1'b1; else nArmed = 1'b1;
              OP_FILL: begin
                if (armed) nState = org16 ? S_DATH : S_DATL;
                else begin badOp = 1'b1; nState = S_ERR; end
              end
              OP_STAT:   stat = 1'b1;
              OP_BSYON:  nBusyEn = 1'b1;
              OP_BSYOFF: nBusyEn = 1'b0;
              OP_ORG8:   nOrg = 1'b0;
              OP_ORG16:  nOrg = 1'b1;
              OP_NOP:    ;
              OP_WPTR, OP_RPTR, OP_ENACC, OP_DISACC, OP_PEDIS: begin
                fwdOpen = 1'b1;
                nState = S_FWD;
              end
              default: begin badOp = 1'b1; nState = S_ERR; end
            endcase
          end
          S_ADRH: begin nAddrHi = rxByte[0]; nState = S_ADRL; end
          S_ADRL: begin
            nWord = candAddr;
            nState = S_IDLE;
            case (op)
              OP_READ:  candRd = 1'b1;
              OP_RSEQ:  candSeq = 1'b1;
              OP_ERASE: candProg = 1'b1;
              default:  nState = org16 ? S_DATH : S_DATL;
            endcase
          end
          S_DATH: begin nDataHi = rxByte; nState = S_DATL; end
          S_DATL: begin
            nState = S_IDLE;
            candAddr = wordReg;
            candData = {dataHi, rxByte};
            if (op == OP_WRITE) candProg = 1'b1; else candAll = 1'b1;
          end
          default: ;
        endcase
      end
    end
    if (cs && state == S_FWD && fwdDone) nState = S_IDLE;
  end

  assign permWordAddr = candAddr;
  assign permProg     = candProg | candAll;
  assign permAll      = candAll;
  assign fwdValid     = fwdOpen | (cs && rxValid && !rxParErr && state == S_FWD);
  assign fwdByte      = rxByte;
  assign errOut       = (state == S_ERR);

  always_comb begin
    st            = '0;
    st.progOne    = candProg && permOk && !busy;
    st.progAll    = candAll && permOk && !busy;
    st.readOne    = candRd && permOk;
    st.readSeq    = candSeq && permOk;
    st.readStat   = stat;
    st.opcodeSeen = cs && rxValid && !rxParErr && state == S_IDLE;
    st.abort      = !cs;
    st.wordAddr   = candAddr;
    st.wordData   = candData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; op <= OP_NOP; addrHi <= 1'b0; dataHi <= '0; wordReg <= '0;
      armed <= 1'b0; busyEn <= 1'b0; org16 <= 1'b0; parErr <= 1'b0; instrErr <= 1'b0;
    end else begin
      state <= nState; op <= nOp; addrHi <= nAddrHi; dataHi <= nDataHi; wordReg <= nWord;
      armed <= nArmed; busyEn <= nBusyEn; org16 <= nOrg;
      if (stat) begin
        parErr <= 1'b0;
        instrErr <= 1'b0;
      end else begin
        if (parHit) parErr <= 1'b1;
        if (badOp) instrErr <= 1'b1;
      end
    end
  end

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (errOut && cs) |=> errOut);
  a_r8_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !errOut);
  a_r13_no_fwd_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |-> !errOut);
endmodule

// File: rtl/seqcmd_dp.sv
module seqcmd_dp
  import seqcmd_pkg::*;
#(
  parameter int PROG_CYCLES = 60000
)(
  input  logic      clk,
  input  logic      rst_n,
  input  dpStrobe_t st,
  input  logic      org16,
  input  logic      busyEn,
  input  logic      parErr,
  input  logic      instrErr,
  input  logic      txReady,
  output logic      txValid,
  output logic [7:0] txByte,
  output logic      busy,
  output logic      doOe,
  output logic      doLevel
);
  localparam int CntW = $clog2(PROG_CYCLES + 1);

  logic [7:0] mem [NumBytes];
  logic [CntW-1:0] busyCnt;
  logic txActive, txStat, showOe;
  logic [ByteAddrW-1:0] txPtr, txLast;
  logic [7:0] statByte;

  always_ff @(posedge clk) begin
    if (st.progAll) begin
      for (int i = 0; i < NumBytes; i++)
        mem[i] <= (org16 && i[0] == 1'b0) ? st.wordData[15:8] : st.wordData[7:0];
    end else if (st.progOne) begin
      if (org16) begin
        mem[{st.wordAddr[ByteAddrW-2:0], 1'b0}] <= st.wordData[15:8];
        mem[{st.wordAddr[ByteAddrW-2:0], 1'b1}] <= st.wordData[7:0];
      end else begin
        mem[st.wordAddr] <= st.wordData[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyCnt <= '0;
    else if (st.progOne || st.progAll) busyCnt <= CntW'(PROG_CYCLES);
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end
  assign busy = (busyCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) showOe <= 1'b0;
    else if ((st.progOne || st.progAll) && busyEn) showOe <= 1'b1;
    else if (st.opcodeSeen && !busy) showOe <= 1'b0;
  end
  assign doOe    = showOe;
  assign doLevel = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txActive <= 1'b0; txStat <= 1'b0; txPtr <= '0; txLast <= '0; statByte <= '0;
    end else if (st.abort) begin
      txActive <= 1'b0;
    end else if (st.readOne || st.readSeq) begin
      txActive <= 1'b1;
      txStat   <= 1'b0;
      txPtr    <= org16 ? {st.wordAddr[ByteAddrW-2:0], 1'b0} : st.wordAddr;
      if (st.readSeq) txLast <= '1;
      else txLast <= org16 ? {st.wordAddr[ByteAddrW-2:0], 1'b1} : st.wordAddr;
    end else if (st.readStat) begin
      txActive <= 1'b1;
      txStat   <= 1'b1;
      statByte <= {3'b101, parErr, instrErr, busy, 2'b00};
    end else if (txActive && txReady) begin
      if (txStat || txPtr == txLast) txActive <= 1'b0;
      else txPtr <= txPtr + 1'b1;
    end
  end
  assign txValid = txActive;
  assign txByte  = txStat ? statByte : mem[txPtr];

  a_r4_busy_from_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st.progOne || st.progAll));
  a_r11_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (txActive && !txStat) |-> (txPtr <= txLast));
endmodule

// File: rtl/serial_mem_sequencer.sv
module serial_mem_sequencer
  import seqcmd_pkg::*;
#(
  parameter int PROG_CYCLES = 60000
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 rxValid,
  input  logic [7:0]           rxByte,
  input  logic                 rxParErr,
  input  logic                 txReady,
  output logic                 txValid,
  output logic [7:0]           txByte,
  output logic                 doOe,
  output logic                 doLevel,
  output logic                 busy,
  output logic                 errOut,
  output logic [ByteAddrW-1:0] permWordAddr,
  output logic                 permProg,
  output logic                 permAll,
  input  logic                 permOk,
  output logic                 fwdValid,
  output logic [7:0]           fwdByte,
  input  logic                 fwdDone
);
  dpStrobe_t st;
  logic parErr, instrErr, busyEn, org16;

  seqcmd_ctrl i_ctrl (
    .clk, .rst_n, .cs, .rxValid, .rxByte, .rxParErr, .busy, .permOk, .fwdDone,
    .st, .permWordAddr, .permProg, .permAll, .fwdValid, .fwdByte, .errOut,
    .parErr, .instrErr, .busyEn, .org16
  );

  seqcmd_dp #(.PROG_CYCLES(PROG_CYCLES)) i_dp (
    .clk, .rst_n, .st, .org16, .busyEn, .parErr, .instrErr, .txReady,
    .txValid, .txByte, .busy, .doOe, .doLevel
  );
endmodule

// File: tb/test_serial_mem_sequencer.sv
module test_serial_mem_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 20;

  logic clk = 0, rst_n = 0, cs = 1, rxValid = 0, rxParErr = 0, txReady = 1, fwdDone = 0;
  logic [7:0] rxByte = 0;
  logic txValid, doOe, doLevel, busy, errOut, permProg, permAll, permOk, fwdValid;
  logic [7:0] txByte, fwdByte;
  logic [8:0] permWordAddr;
  logic [8:0] lockLimit = 0;

  int checks = 0, errors = 0, busyLeft = 0, fwdCount = 0;
  bit monOn = 0;
  logic [7:0] fwdLast;
  logic [7:0] model [512];
  logic [7:0] q [$];
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign permOk = !(permProg && !permAll && permWordAddr < lockLimit);

  serial_mem_sequencer #(.PROG_CYCLES(PROG)) i_serial_mem_sequencer (
    .clk, .rst_n, .cs, .rxValid, .rxByte, .rxParErr, .txReady, .txValid, .txByte,
    .doOe, .doLevel, .busy, .errOut, .permWordAddr, .permProg, .permAll, .permOk,
    .fwdValid, .fwdByte, .fwdDone
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (monOn) begin
      chk(busy === (busyLeft > 0), "R4", "busy level", busy, busyLeft > 0);
      if (busyLeft > 0) busyLeft--;
      if (txValid === 1'b1) begin
        if (q.size() == 0) chk(0, curReq, "unexpected tx byte", txByte, 0);
        else begin
          chk(txByte === q[0], curReq, "tx byte", txByte, q[0]);
          if (txReady) void'(q.pop_front());
        end
      end
    end
  end

  always @(negedge clk) begin
    #3;
    if (fwdValid === 1'b1) begin fwdCount++; fwdLast = fwdByte; end
  end

  task automatic sendB(input logic [7:0] b, input bit par = 0);
    @(negedge clk);
    rxValid = 1; rxByte = b; rxParErr = par;
    @(posedge clk); #1;
    rxValid = 0; rxParErr = 0;
  endtask

  task automatic wr8(input logic [8:0] a, input logic [7:0] d, input bit granted);
    sendB(8'hC1); sendB({7'b0, a[8]}); sendB(a[7:0]); sendB(d);
    if (granted) begin busyLeft = PROG; model[a] = d; end
  endtask

  task automatic rd8(input logic [8:0] a);
    sendB(8'hC9); sendB({7'b0, a[8]}); sendB(a[7:0]);
    q.push_back(model[a]);
  endtask

  task automatic statRd(input logic [7:0] exp);
    sendB(8'hC8); q.push_back(exp);
  endtask

  task automatic waitQ;
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic waitIdle;
    while (busyLeft > 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic csPulse;
    @(negedge clk); cs = 0;
    @(posedge clk); #1; q.delete();
    @(negedge clk); cs = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", "run did not end", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    monOn = 1;
    @(negedge clk);
    // R1: reset state
    chk(txValid === 0 && errOut === 0 && doOe === 0 && busy === 0, "R1", "idle outputs",
        {txValid, errOut, doOe, busy}, 0);
    statRd(8'hA0); waitQ();

    // R5: double clear-all
    curReq = "R5";
    sendB(8'h89); sendB(8'h89); busyLeft = PROG;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    waitIdle(); rd8(9'h005); waitQ();

    // R2, R3: 8-bit write and read, high address byte first
    curReq = "R2";
    wr8(9'h105, 8'h3C, 1); waitIdle();
    wr8(9'h005, 8'h77, 1); waitIdle();
    rd8(9'h105); rd8(9'h005); waitQ();

    // R14, R3: 16-bit organisation
    curReq = "R14";
    sendB(8'h87);
    sendB(8'hC1); sendB(8'h10); sendB(8'hAB); sendB(8'hCD);
    busyLeft = PROG; model[9'h020] = 8'hAB; model[9'h021] = 8'hCD;
    waitIdle();
    sendB(8'hC9); sendB(8'h10); q.push_back(8'hAB); q.push_back(8'hCD); waitQ();
    sendB(8'h86);
    rd8(9'h020); rd8(9'h021); waitQ();

    // R3: erase
    curReq = "R3";
    sendB(8'hC0); sendB(8'h00); sendB(8'h20); busyLeft = PROG; model[9'h020] = 8'hFF;
    waitIdle(); rd8(9'h020); waitQ();

    // R4: program while busy is dropped; R7 busy bit in status
    curReq = "R4";
    wr8(9'h030, 8'h11, 1);
    wr8(9'h030, 8'h22, 0);
    curReq = "R7";
    statRd(8'hA4); waitQ();
    waitIdle();
    curReq = "R4";
    rd8(9'h030); waitQ();

    // R6: write-all
    curReq = "R6";
    sendB(8'h89); sendB(8'hC3); sendB(8'h5A); busyLeft = PROG;
    for (int i = 0; i < 512; i++) model[i] = 8'h5A;
    waitIdle(); rd8(9'h1FF); rd8(9'h000); waitQ();

    // R5: single clear-all has no effect
    curReq = "R5";
    sendB(8'h89); sendB(8'h80);
    repeat (3) @(posedge clk);
    rd8(9'h000); waitQ();

    // R11: sequential read to top of array
    curReq = "R11";
    wr8(9'h1FE, 8'hE1, 1); waitIdle();
    sendB(8'hCB); sendB(8'h01); sendB(8'hFC);
    for (int i = 9'h1FC; i < 512; i++) q.push_back(model[i]);
    waitQ();
    chk(txValid === 0, "R11", "stream stops at top", txValid, 0);
    sendB(8'hCB); sendB(8'h00); sendB(8'h00);
    for (int i = 0; i < 512; i++) q.push_back(model[i]);
    repeat (3) @(posedge clk);
    csPulse();
    @(negedge clk);
    chk(txValid === 0, "R11", "stream ends on cs low", txValid, 0);

    // R12: denied command dropped
    curReq = "R12";
    lockLimit = 9'h040;
    wr8(9'h010, 8'h99, 0);
    repeat (3) @(posedge clk);
    lockLimit = 0;
    rd8(9'h010); waitQ();

    // R10: busy indication on the data line
    curReq = "R10";
    sendB(8'h84);
    wr8(9'h050, 8'h42, 1);
    @(negedge clk); #1;
    chk(doOe === 1 && doLevel === 0, "R10", "data line low while busy", {doOe, doLevel}, 2'b10);
    waitIdle();
    chk(doOe === 1 && doLevel === 1, "R10", "data line high when done", {doOe, doLevel}, 2'b11);
    sendB(8'h80);
    @(negedge clk); #1;
    chk(doOe === 0, "R10", "released after opcode", doOe, 0);
    sendB(8'h85);
    wr8(9'h051, 8'h43, 1);
    @(negedge clk); #1;
    chk(doOe === 0, "R10", "off after disable", doOe, 0);
    waitIdle();

    // R13: forwarded opcode
    curReq = "R13";
    fwdCount = 0;
    sendB(8'hC5); sendB(8'h12);
    @(negedge clk); #1;
    chk(fwdCount == 2 && fwdLast == 8'h12, "R13", "forwarded bytes", fwdCount, 2);
    @(negedge clk); fwdDone = 1;
    @(negedge clk); fwdDone = 0;
    statRd(8'hA0); waitQ();
    chk(fwdCount == 2, "R13", "no forward after done", fwdCount, 2);

    // R8: unknown opcode stops the block; cs low restores, org kept
    curReq = "R8";
    sendB(8'h87);
    sendB(8'h8F);
    @(negedge clk); #1;
    chk(errOut === 1, "R8", "errOut on unknown opcode", errOut, 1);
    sendB(8'hC8);
    repeat (3) @(posedge clk);
    chk(errOut === 1, "R8", "errOut held", errOut, 1);
    csPulse();
    @(negedge clk); #1;
    chk(errOut === 0, "R8", "errOut cleared by cs", errOut, 0);
    sendB(8'hC9); sendB(8'h10); q.push_back(model[9'h020]); q.push_back(model[9'h021]); waitQ();
    curReq = "R7";
    statRd(8'hA8); waitQ();
    statRd(8'hA0); waitQ();
    sendB(8'h86);

    // R9: parity error
    curReq = "R9";
    sendB(8'h80, 1);
    @(negedge clk); #1;
    chk(errOut === 1, "R9", "errOut on parity error", errOut, 1);
    csPulse();
    statRd(8'hB0); waitQ();

    repeat (5) @(posedge clk);
    chk(q.size() == 0, "R11", "all expected bytes seen", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule